// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer Bank

This block sits on a simple register bus and holds four identical 32-bit down-counters. A top-level control register carries a master enable, a read-only identification word reports the build revision, and each timer has its own 32-byte register window. Each timer has a local enable, a reload value, a wrap counter, an event status bit, a clear strobe and an interrupt mask. A timer counts down once per clock while the master enable and its local enable are both set. When it steps from zero it reloads, bumps its wrap counter and records an event. Any masked-in event drives the single combined interrupt line.

Software reads a timer in two steps. Reading the wrap-count register returns the number of wraps so far and, on the same access, freezes the live counter into a snapshot register. A following read of the count register returns that frozen value. So reading the wrap count first and the count second gives a matched pair. Counting software usually inverts the down-count to get an up-count. With the default all-ones reload, the inverted value climbs from zero across the full 32-bit range.

Top module: `tmr_bank`

## Requirements
- R1: After reset the master enable reads 0. Every reload register reads 0xFFFFFFFF. Status, mask, wrap counter and snapshot of every timer read 0, and `irq` is 0.
- R2: The word at byte address 0x10 always reads the parameter `REV_ID`, and writes to it have no effect.
- R3: Timer n (0..3) occupies bytes 0x20*(n+1) up to 0x20*(n+1)+0x1F. Inside a window the offsets are: 0x00 enable (bit 0), 0x04 reload, 0x08 snapshot count, 0x0C wrap count, 0x10 status (bit 0), 0x14 clear (bit 0, write-one), 0x18 mask (bit 0). The master enable is bit 0 of byte address 0x00. A write to one timer's window leaves every other timer unchanged.
- R4: While both enables are 1, a timer with reload R visits R, R-1, ..., 0 and then R again, one step per clock, a period of R+1 clocks. Each step out of zero adds 1 to its wrap counter. A reload of 0 wraps on every clock.
- R5: While a timer's local enable is 0, its counter takes the reload value one clock later. Setting the local enable starts the count from the reload value.
- R6: While the master enable is 0, every counter whose local enable is 1 holds its value.
- R7: A read of the wrap-count register captures the counter value that was present at that access. Count-register reads return the captured value, and it stays unchanged until the next wrap-count read.
- R8: A wrap sets status bit 0. Writing 1 to clear bit 0 resets it, but a wrap in the same clock keeps it set.
- R9: `irq` is high exactly when some timer has status 1 and mask 1. With the mask at 0, the status still records wraps while `irq` stays low.
- R10: Unmapped addresses and the clear register read 0. Writes to unmapped addresses and to the count, wrap-count and status registers change nothing.
- R11: With the reset reload of 0xFFFFFFFF, the bitwise inverse of the captured count equals the number of clocks the timer has been counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| rd_en | input | 1 | Read strobe, sampled on the rising edge |
| addr | input | ADDR_W | Byte address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, registered, holds between reads |
| irq | output | 1 | Combined interrupt |

## Verification
Read data is registered. A read strobe sampled at edge k puts the value that was present before edge k onto `rdata`, valid from just after that edge. A write sampled at edge k takes effect at edge k. `irq` follows from the status and mask registers with no further delay. After the write that enables a timer at edge E0, the counter holds R - (j mod (R+1)) after edge Ej, and its wrap count has grown by floor(j/(R+1)). A capture at edge E(1+d) therefore returns the value after d edges. The bench drives strobes on the falling edge, counts every edge from the enable write, and samples `rdata` and `irq` on the falling edge after the edge concerned. It also places a clear write exactly on a wrap edge to test the priority rule.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // Byte-address split: upper bits pick a window, lower bits a register.
  localparam int WIN_SH = 5;

  localparam logic [WIN_SH-1:0] OFF_CFG = 5'h00;
  localparam logic [WIN_SH-1:0] OFF_RLD = 5'h04;
  localparam logic [WIN_SH-1:0] OFF_CNT = 5'h08;
  localparam logic [WIN_SH-1:0] OFF_OVF = 5'h0C;
  localparam logic [WIN_SH-1:0] OFF_STS = 5'h10;
  localparam logic [WIN_SH-1:0] OFF_CLR = 5'h14;
  localparam logic [WIN_SH-1:0] OFF_MSK = 5'h18;

  // Top window (window 0) registers.
  localparam logic [WIN_SH-1:0] OFF_CTRL = 5'h00;
  localparam logic [WIN_SH-1:0] OFF_REV  = 5'h10;

  typedef enum logic [2:0] {
    REG_CFG,
    REG_RLD,
    REG_CNT,
    REG_OVF,
    REG_STS,
    REG_CLR,
    REG_MSK,
    REG_NONE
  } reg_sel_e;

endpackage

// File: rtl/tmr_addr_dec.sv
module tmr_addr_dec
  import tmr_pkg::*;
#(
  parameter int NUM_TMR = 4,
  parameter int ADDR_W  = 8
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic               ctrl_hit,
  output logic               rev_hit,
  output logic [NUM_TMR-1:0] tmr_hit,
  output reg_sel_e           reg_sel
);

  localparam int WIN_W = ADDR_W - WIN_SH;

  logic [WIN_W-1:0]  win;
  logic [WIN_SH-1:0] off;

  assign win = addr[ADDR_W-1:WIN_SH];
  assign off = addr[WIN_SH-1:0];

  always_comb begin
    unique case (off)
      OFF_CFG: reg_sel = REG_CFG;
      OFF_RLD: reg_sel = REG_RLD;
      OFF_CNT: reg_sel = REG_CNT;
      OFF_OVF: reg_sel = REG_OVF;
      OFF_STS: reg_sel = REG_STS;
      OFF_CLR: reg_sel = REG_CLR;
      OFF_MSK: reg_sel = REG_MSK;
      default: reg_sel = REG_NONE;
    endcase
  end

  assign ctrl_hit = (win == '0) && (off == OFF_CTRL);
  assign rev_hit  = (win == '0) && (off == OFF_REV);

  for (genvar n = 0; n < NUM_TMR; n++) begin : g_hit
    assign tmr_hit[n] = (win == WIN_W'(n + 1)) && (reg_sel != REG_NONE);
  end

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              glb_en,
  input  logic              wr_cfg,
  input  logic              wr_rld,
  input  logic              wr_clr,
  input  logic              wr_msk,
  input  logic              snap_req,
  input  logic [DATA_W-1:0] wdata,
  output logic              len_o,
  output logic [DATA_W-1:0] rld_o,
  output logic [DATA_W-1:0] cnt_o,
  output logic [DATA_W-1:0] snap_o,
  output logic [DATA_W-1:0] ovf_o,
  output logic              sts_o,
  output logic              msk_o,
  output logic              ev_o
);

  logic              len_q, len_d;
  logic              sts_q, sts_d;
  logic              msk_q, msk_d;
  logic [DATA_W-1:0] rld_q, rld_d;
  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic [DATA_W-1:0] snap_q, snap_d;
  logic [DATA_W-1:0] ovf_q, ovf_d;
  logic              run;
  logic              wrap;

  // Next-state logic
  always_comb begin
    run  = glb_en & len_q;
    wrap = run & (cnt_q == '0);

    if (!len_q)        cnt_d = rld_q;
    else if (!glb_en)  cnt_d = cnt_q;
    else if (wrap)     cnt_d = rld_q;
    else               cnt_d = cnt_q - DATA_W'(1);

    ovf_d  = ovf_q + DATA_W'(wrap);
    snap_d = snap_req ? cnt_q : snap_q;
    len_d  = wr_cfg ? wdata[0] : len_q;
    msk_d  = wr_msk ? wdata[0] : msk_q;
    rld_d  = wr_rld ? wdata : rld_q;

    // A wrap in the same clock overrides a clear request.
    if (wrap)                     sts_d = 1'b1;
    else if (wr_clr && wdata[0])  sts_d = 1'b0;
    else                          sts_d = sts_q;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= 1'b0;
      sts_q  <= 1'b0;
      msk_q  <= 1'b0;
      rld_q  <= '1;
      cnt_q  <= '0;
      snap_q <= '0;
      ovf_q  <= '0;
    end else begin
      len_q  <= len_d;
      sts_q  <= sts_d;
      msk_q  <= msk_d;
      rld_q  <= rld_d;
      cnt_q  <= cnt_d;
      snap_q <= snap_d;
      ovf_q  <= ovf_d;
    end
  end

  assign len_o  = len_q;
  assign rld_o  = rld_q;
  assign cnt_o  = cnt_q;
  assign snap_o = snap_q;
  assign ovf_o  = ovf_q;
  assign sts_o  = sts_q;
  assign msk_o  = msk_q;
  assign ev_o   = wrap;

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int          NUM_TMR = 4,
  parameter int          DATA_W  = 32,
  parameter int          ADDR_W  = 8,
  parameter logic [31:0] REV_ID  = 32'h0001_0203
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Address decode
  logic               ctrl_hit;
  logic               rev_hit;
  logic [NUM_TMR-1:0] tmr_hit;
  reg_sel_e           reg_sel;

  tmr_addr_dec #(
    .NUM_TMR (NUM_TMR),
    .ADDR_W  (ADDR_W)
  ) u_dec (
    .addr     (addr),
    .ctrl_hit (ctrl_hit),
    .rev_hit  (rev_hit),
    .tmr_hit  (tmr_hit),
    .reg_sel  (reg_sel)
  );

  // Master enable
  logic glb_q, glb_d;

  always_comb glb_d = (wr_en && ctrl_hit) ? wdata[0] : glb_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) glb_q <= 1'b0;
    else            glb_q <= glb_d;
  end

  // Timer channels
  logic [NUM_TMR-1:0]             len_vec;
  logic [NUM_TMR-1:0]             sts_vec;
  logic [NUM_TMR-1:0]             msk_vec;
  logic [NUM_TMR-1:0]             ev_vec;
  logic [NUM_TMR-1:0][DATA_W-1:0] rld_vec;
  logic [NUM_TMR-1:0][DATA_W-1:0] cnt_vec;
  logic [NUM_TMR-1:0][DATA_W-1:0] snap_vec;
  logic [NUM_TMR-1:0][DATA_W-1:0] ovf_vec;

  for (genvar n = 0; n < NUM_TMR; n++) begin : g_tmr
    logic wsel;
    assign wsel = wr_en & tmr_hit[n];

    tmr_chan #(
      .DATA_W (DATA_W)
    ) u_chan (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .glb_en   (glb_q),
      .wr_cfg   (wsel && (reg_sel == REG_CFG)),
      .wr_rld   (wsel && (reg_sel == REG_RLD)),
      .wr_clr   (wsel && (reg_sel == REG_CLR)),
      .wr_msk   (wsel && (reg_sel == REG_MSK)),
      .snap_req (rd_en && tmr_hit[n] && (reg_sel == REG_OVF)),
      .wdata    (wdata),
      .len_o    (len_vec[n]),
      .rld_o    (rld_vec[n]),
      .cnt_o    (cnt_vec[n]),
      .snap_o   (snap_vec[n]),
      .ovf_o    (ovf_vec[n]),
      .sts_o    (sts_vec[n]),
      .msk_o    (msk_vec[n]),
      .ev_o     (ev_vec[n])
    );
  end

  // Read mux and registered read data
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  always_comb begin
    rd_mux = '0;
    if (ctrl_hit) rd_mux = {{(DATA_W-1){1'b0}}, glb_q};
    if (rev_hit)  rd_mux = DATA_W'(REV_ID);
    for (int i = 0; i < NUM_TMR; i++) begin
      if (tmr_hit[i]) begin
        unique case (reg_sel)
          REG_CFG: rd_mux = {{(DATA_W-1){1'b0}}, len_vec[i]};
          REG_RLD: rd_mux = rld_vec[i];
          REG_CNT: rd_mux = snap_vec[i];
          REG_OVF: rd_mux = ovf_vec[i];
          REG_STS: rd_mux = {{(DATA_W-1){1'b0}}, sts_vec[i]};
          REG_MSK: rd_mux = {{(DATA_W-1){1'b0}}, msk_vec[i]};
          default: rd_mux = '0;
        endcase
      end
    end
    rdata_d = rd_en ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rdata_q <= '0;
    else            rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;
  assign irq   = |(sts_vec & msk_vec);

endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk #(
  parameter int          NUM_TMR = 4,
  parameter int          DATA_W  = 32,
  parameter int          ADDR_W  = 8,
  parameter logic [31:0] REV_ID  = 32'h0001_0203
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             rd_en,
  input logic [ADDR_W-1:0]                addr,
  input logic [DATA_W-1:0]                rdata,
  input logic                             irq,
  input logic                             glb_en,
  input logic [NUM_TMR-1:0]               len_vec,
  input logic [NUM_TMR-1:0]               ev_vec,
  input logic [NUM_TMR-1:0]               sts_vec,
  input logic [NUM_TMR-1:0]               msk_vec,
  input logic [NUM_TMR-1:0][DATA_W-1:0]   cnt_vec,
  input logic [NUM_TMR-1:0][DATA_W-1:0]   rld_vec
);

  // R2: identification word always reads back its parameter
  assert_rev_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(16)) |=> (rdata == DATA_W'(REV_ID)));

  // R9: no mask bit set means no interrupt
  assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_vec == '0) |-> !irq);

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_t
    // R4: one step down per clock while running
    assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (glb_en && len_vec[i] && cnt_vec[i] != '0)
        |=> (cnt_vec[i] == $past(cnt_vec[i]) - DATA_W'(1)));

    // R4: leaving zero reloads
    assert_wrap_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (glb_en && len_vec[i] && cnt_vec[i] == '0)
        |=> (cnt_vec[i] == $past(rld_vec[i])));

    // R5: stopped counter tracks reload
    assert_follow_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !len_vec[i] |=> (cnt_vec[i] == $past(rld_vec[i])));

    // R6: master enable off freezes enabled counters
    assert_hold_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!glb_en && len_vec[i]) |=> $stable(cnt_vec[i]));

    // R8: a wrap always leaves status set
    assert_wrap_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ev_vec[i] |=> sts_vec[i]);
  end

endmodule

bind tmr_bank tmr_bank_chk #(
  .NUM_TMR (NUM_TMR),
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W),
  .REV_ID  (REV_ID)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_int_n),
  .rd_en   (rd_en),
  .addr    (addr),
  .rdata   (rdata),
  .irq     (irq),
  .glb_en  (glb_q),
  .len_vec (len_vec),
  .ev_vec  (ev_vec),
  .sts_vec (sts_vec),
  .msk_vec (msk_vec),
  .cnt_vec (cnt_vec),
  .rld_vec (rld_vec)
);

// File: tb/tmr_bank_bench.sv
`timescale 1ns/1ps
module tmr_bank_bench;

  localparam logic [31:0] REV = 32'h0001_0203;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic        rd_en;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  int n_chk;
  int n_bad;

  tmr_bank #(.NUM_TMR(4), .DATA_W(32), .ADDR_W(8), .REV_ID(REV)) u_tmr_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Register offsets inside a timer window
  localparam logic [7:0] O_CFG = 8'h00, O_RLD = 8'h04, O_CNT = 8'h08,
                         O_OVF = 8'h0C, O_STS = 8'h10, O_CLR = 8'h14,
                         O_MSK = 8'h18;

  function automatic logic [7:0] ta(int n, logic [7:0] off);
    return 8'(8'h20 * (n + 1)) + off;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Every bus task starts and ends on a falling edge and spans one rising edge.
  task automatic wr(logic [7:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h00, v);          chk("R1 master enable", v, 32'h0);
    for (int n = 0; n < 4; n++) begin
      rd(ta(n, O_RLD), v); chk("R1 reload", v, 32'hFFFF_FFFF);
      rd(ta(n, O_STS), v); chk("R1 status", v, 32'h0);
      rd(ta(n, O_MSK), v); chk("R1 mask", v, 32'h0);
      rd(ta(n, O_CNT), v); chk("R1 snapshot", v, 32'h0);
      rd(ta(n, O_OVF), v); chk("R1 wrap count", v, 32'h0);
    end
    chk("R1 irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_rev;
    logic [31:0] v;
    rd(8'h10, v);          chk("R2 revision", v, REV);
    wr(8'h10, 32'hDEAD_BEEF);
    rd(8'h10, v);          chk("R2 revision after write", v, REV);
  endtask

  // R4/R5/R7: run timer n with reload r for d clocks, then capture.
  task automatic t_measure(int n, logic [31:0] r, int d);
    logic [31:0] base, v, exp_cnt;
    longint per;
    wr(ta(n, O_CFG), 32'h0);
    rd(ta(n, O_OVF), base);
    wr(ta(n, O_RLD), r);
    idle(1);
    wr(ta(n, O_CFG), 32'h1);          // edge E0
    idle(d);
    per = longint'(r) + 1;
    exp_cnt = 32'(longint'(r) - (d % per));
    rd(ta(n, O_OVF), v);              // captures at E(1+d)
    chk("R4 wrap count", v, 32'(longint'(base) + d / per));
    rd(ta(n, O_CNT), v);  chk("R7 captured count", v, exp_cnt);
    idle(4);
    rd(ta(n, O_CNT), v);  chk("R7 capture held", v, exp_cnt);
  endtask

  task automatic t_follow;
    logic [31:0] v;
    wr(ta(2, O_CFG), 32'h0);
    wr(ta(2, O_RLD), 32'd77);
    idle(1);
    rd(ta(2, O_OVF), v);
    rd(ta(2, O_CNT), v);  chk("R5 stopped count follows reload", v, 32'd77);
  endtask

  task automatic t_freeze;
    logic [31:0] v;
    wr(ta(2, O_CFG), 32'h0);
    wr(ta(2, O_RLD), 32'd100);
    idle(1);
    wr(ta(2, O_CFG), 32'h1);          // E0
    idle(5);
    wr(8'h00, 32'h0);                 // E6: still counts on this edge
    idle(10);
    rd(ta(2, O_OVF), v);
    rd(ta(2, O_CNT), v);  chk("R6 frozen count", v, 32'd94);
    wr(8'h00, 32'h1);
  endtask

  task automatic t_full_range;
    logic [31:0] v;
    wr(ta(0, O_CFG), 32'h1);          // E0, reload untouched since reset
    idle(9);
    rd(ta(0, O_OVF), v);
    rd(ta(0, O_CNT), v);  chk("R11 inverted count", ~v, 32'd9);
    wr(ta(0, O_CFG), 32'h0);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    wr(ta(3, O_CFG), 32'h0);
    wr(ta(3, O_CLR), 32'h1);
    wr(ta(3, O_RLD), 32'd3);
    idle(1);
    wr(ta(3, O_CFG), 32'h1);          // E0; wraps at E4, E8, E12, ...
    idle(6);
    rd(ta(3, O_STS), v);  chk("R9 status with mask off", v, 32'h1);   // E7
    chk("R9 irq with mask off", {31'h0, irq}, 32'h0);
    wr(ta(3, O_MSK), 32'h1);          // E8
    chk("R9 irq raised", {31'h0, irq}, 32'h1);
    wr(ta(3, O_CLR), 32'h1);          // E9, no wrap
    chk("R8 irq after clear", {31'h0, irq}, 32'h0);
    rd(ta(3, O_STS), v);  chk("R8 status cleared", v, 32'h0);         // E10
    idle(1);
    wr(ta(3, O_CLR), 32'h1);          // E12, wrap wins
    chk("R8 irq wrap beats clear", {31'h0, irq}, 32'h1);
    rd(ta(3, O_STS), v);  chk("R8 status wrap beats clear", v, 32'h1); // E13
    wr(ta(3, O_CFG), 32'h0);          // E14
    wr(ta(3, O_CLR), 32'h1);          // E15
    rd(ta(3, O_STS), v);  chk("R8 status final clear", v, 32'h0);
    chk("R9 irq final", {31'h0, irq}, 32'h0);
    wr(ta(3, O_MSK), 32'h0);
  endtask

  task automatic t_windows;
    logic [31:0] v;
    wr(ta(2, O_MSK), 32'h1);
    rd(ta(1, O_MSK), v);  chk("R3 timer1 mask untouched", v, 32'h0);
    rd(ta(2, O_MSK), v);  chk("R3 timer2 mask set", v, 32'h1);
    rd(ta(3, O_MSK), v);  chk("R3 timer3 mask untouched", v, 32'h0);
    wr(ta(2, O_MSK), 32'h0);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    rd(8'h04, v);          chk("R10 unmapped top read", v, 32'h0);
    rd(8'hA0, v);          chk("R10 missing window read", v, 32'h0);
    rd(ta(0, 8'h1C), v);   chk("R10 unmapped offset read", v, 32'h0);
    rd(ta(1, O_CLR), v);   chk("R10 clear reads zero", v, 32'h0);
    wr(8'h04, 32'h0);
    wr(8'hA0, 32'h1);
    rd(8'h00, v);          chk("R10 master enable intact", v, 32'h1);
    wr(ta(1, O_CFG), 32'h0);
    wr(ta(1, O_RLD), 32'd9);
    idle(1);
    rd(ta(1, O_OVF), v);
    wr(ta(1, O_CNT), 32'h1234);
    wr(ta(1, O_OVF), 32'h5678);
    rd(ta(1, O_CNT), v);   chk("R10 count write ignored", v, 32'd9);
    wr(ta(1, O_STS), 32'h1);
    wr(ta(1, O_CLR), 32'h1);
    wr(ta(1, O_STS), 32'h1);
    rd(ta(1, O_STS), v);   chk("R10 status write ignored", v, 32'h0);
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset;
    t_rev;
    wr(8'h00, 32'h1);
    t_measure(1, 32'd5, 3);
    t_measure(1, 32'd5, 13);
    t_measure(2, 32'd0, 4);
    t_follow;
    t_freeze;
    t_full_range;
    t_irq;
    t_windows;
    t_unmapped;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule